// File: doc/BRIEF.md
# Late-Write Pipelined SRAM Core

A synchronous single-port memory holding words of 36 bits, split into four byte lanes of 9 bits each. A command is taken on every rising clock edge. It is a deselect, a read or a write, and it is decoded from an active-low chip enable and an active-low write enable. Four active-low lane selects pick which lanes a write touches.

Reads are pipelined by one register. The word for a read taken at edge N is driven from edge N+1 until edge N+2. Writes use a late-data scheme: the write data for a command taken at edge N is sampled at edge N+2. This places it in the same bus slot that a read issued at edge N would occupy. Because the two kinds of command use the same slot, reads and writes can be mixed in any order on consecutive edges, and the shared data bus needs no turnaround cycle.

The bidirectional data pins are modelled as a data-in bus, a data-out bus and an output-drive flag. An asynchronous active-low output enable can only narrow the drive window that the pipeline grants.

Top module: `sram_lw_core`

## Requirements
- R1: Every command input is sampled on the rising edge of `clk_i`. When `ce_ni` is sampled high, the edge is a deselect: nothing is stored, even with `we_ni` and all lane selects low, and no read result is produced.
- R2: When `ce_ni` and `we_ni` are sampled low at edge N, a write is started. The word on `wdata_i` at edge N+2 is stored at the address sampled at edge N.
- R3: Lane selects are active low and apply only to writes. `bws_ni[0]` guards bits 8:0, `bws_ni[1]` guards bits 17:9, `bws_ni[2]` guards bits 26:18 and `bws_ni[3]` guards bits 35:27. A lane whose select is high keeps its old content.
- R4: When `ce_ni` is low and `we_ni` is high at edge N, a read is started. The stored word appears on `rdata_o` after edge N+1, and `rdata_o` holds that word until the next read result replaces it.
- R5: `drive_o` is low in the write data slot, in the first slot after a deselect, and in every deselected slot, whatever the level of `oe_ni`. It is high only in the slot that follows a read command.
- R6: `oe_ni` acts asynchronously. While it is high, `drive_o` is low within the same cycle.
- R7: Reads and writes to any addresses may alternate on consecutive edges with no idle cycle, and every read returns the correct word.
- R8: A read issued on the edge right after a write to the same address returns the newly written lanes, merged with the old content of the unselected lanes.
- R9: An active-low reset `rst_ni` clears the command pipeline, `drive_o` and `rdata_o`. It does not clear the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all commands are taken on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the pipeline |
| addr_i | input | AW | Word address, AW = clog2(DEPTH) |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low; high selects a read |
| bws_ni | input | 4 | Lane write selects, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | 36 | Write data, sampled two edges after its command |
| rdata_o | output | 36 | Read data register |
| drive_o | output | 1 | High while the block would drive the data pins |

## Verification
The bench builds the core with DEPTH set to 16. This keeps the number of addresses small enough that every word is first filled with a full-lane write, so no read ever returns an unwritten value. It also makes it cheap to aim reads, lane-masked writes and forwarding at the same few addresses. A reference model inside the bench replays each command stream, so drive and data are checked on every edge for alternating, forwarded, deselected and reset sequences.

// File: rtl/sram_lw_pkg.sv
package sram_lw_pkg;
  localparam int NUM_LANES = 4;
  localparam int LANE_W    = 9;
  localparam int WORD_W    = NUM_LANES * LANE_W;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lw_cmd_pipe.sv
module lw_cmd_pipe
  import sram_lw_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_ni,
  input  logic                 we_ni,
  input  logic [NUM_LANES-1:0] bws_ni,
  input  logic [AW-1:0]        addr_i,
  output op_e                  s1_op_o,
  output logic [AW-1:0]        s1_addr_o,
  output op_e                  s2_op_o,
  output logic [AW-1:0]        s2_addr_o,
  output logic [NUM_LANES-1:0] s2_be_o
);
  op_e                  s1_op_q, s2_op_q;
  logic [AW-1:0]        s1_addr_q, s2_addr_q;
  logic [NUM_LANES-1:0] s1_be_q, s2_be_q;
  op_e                  cmd_op;

  always_comb begin
    if (ce_ni)      cmd_op = OP_IDLE;
    else if (we_ni) cmd_op = OP_READ;
    else            cmd_op = OP_WRITE;
  end

  // only the op fields need reset; address and mask are qualified by them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_op_q <= OP_IDLE;
      s2_op_q <= OP_IDLE;
    end else begin
      s1_op_q <= cmd_op;
      s2_op_q <= s1_op_q;
    end
  end

  always_ff @(posedge clk_i) begin
    s1_addr_q <= addr_i;
    s1_be_q   <= ~bws_ni;
    s2_addr_q <= s1_addr_q;
    s2_be_q   <= s1_be_q;
  end

  assign s1_op_o   = s1_op_q;
  assign s1_addr_o = s1_addr_q;
  assign s2_op_o   = s2_op_q;
  assign s2_addr_o = s2_addr_q;
  assign s2_be_o   = s2_be_q;
endmodule

// File: rtl/lw_lane_array.sv
module lw_lane_array
  import sram_lw_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic                 clk_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [NUM_LANES-1:0] wr_be_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [WORD_W-1:0]    rd_data_o
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_be_i[g])
        mem_q[wr_addr_i] <= wr_data_i[g*LANE_W +: LANE_W];
    end

    assign rd_data_o[g*LANE_W +: LANE_W] = mem_q[rd_addr_i];
  end
endmodule

// File: rtl/lw_read_stage.sv
module lw_read_stage
  import sram_lw_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_go_i,
  input  logic [WORD_W-1:0]    arr_data_i,
  input  logic                 fwd_hit_i,
  input  logic [NUM_LANES-1:0] fwd_be_i,
  input  logic [WORD_W-1:0]    fwd_data_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic                 drive_q_o
);
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] rdata_q;
  logic              drive_q;

  // lane-wise bypass of the write being committed on this same edge
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (fwd_hit_i && fwd_be_i[g])
                                      ? fwd_data_i[g*LANE_W +: LANE_W]
                                      : arr_data_i[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      drive_q <= 1'b0;
    end else begin
      drive_q <= rd_go_i;
      if (rd_go_i) rdata_q <= merged;
    end
  end

  assign rdata_o   = rdata_q;
  assign drive_q_o = drive_q;
endmodule

// File: rtl/sram_lw_core.sv
module sram_lw_core
  import sram_lw_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic                 ce_ni,
  input  logic                 we_ni,
  input  logic [NUM_LANES-1:0] bws_ni,
  input  logic                 oe_ni,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic                 drive_o
);
  op_e                  s1_op, s2_op;
  logic [AW-1:0]        s1_addr, s2_addr;
  logic [NUM_LANES-1:0] s2_be;
  logic [WORD_W-1:0]    arr_data;
  logic                 commit, rd_go, fwd_hit, drive_q;

  lw_cmd_pipe #(.AW(AW)) u_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .we_ni    (we_ni),
    .bws_ni   (bws_ni),
    .addr_i   (addr_i),
    .s1_op_o  (s1_op),
    .s1_addr_o(s1_addr),
    .s2_op_o  (s2_op),
    .s2_addr_o(s2_addr),
    .s2_be_o  (s2_be)
  );

  // a write reaches the array on the edge where its data is sampled
  assign commit  = (s2_op == OP_WRITE);
  assign rd_go   = (s1_op == OP_READ);
  assign fwd_hit = commit && (s2_addr == s1_addr);

  lw_lane_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk_i    (clk_i),
    .wr_en_i  (commit),
    .wr_addr_i(s2_addr),
    .wr_be_i  (s2_be),
    .wr_data_i(wdata_i),
    .rd_addr_i(s1_addr),
    .rd_data_o(arr_data)
  );

  lw_read_stage u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_go_i   (rd_go),
    .arr_data_i(arr_data),
    .fwd_hit_i (fwd_hit),
    .fwd_be_i  (s2_be),
    .fwd_data_i(wdata_i),
    .rdata_o   (rdata_o),
    .drive_q_o (drive_q)
  );

  assign drive_o = drive_q & ~oe_ni;
endmodule

// File: rtl/sram_lw_core_chk.sv
module sram_lw_core_chk
  import sram_lw_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic [WORD_W-1:0] rdata_o,
  input logic              drive_o
);
  // edges seen since reset release, saturating at 2
  logic [1:0] seen_q;
  logic       armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           seen_q <= 2'd0;
    else if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
  end
  assign armed = (seen_q == 2'd2);

  AST_DRIVE_FROM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    drive_o |-> $past(!ce_ni && we_ni, 2)); // R4
  AST_NO_DRIVE_WRITE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(!ce_ni && !we_ni, 2) |-> !drive_o); // R5
  AST_NO_DRIVE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(ce_ni, 2) |-> !drive_o); // R5
  AST_OE_GATES_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    drive_o |-> !oe_ni); // R6
  AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(ce_ni || !we_ni, 2) |-> $stable(rdata_o)); // R4
endmodule

bind sram_lw_core sram_lw_core_chk u_chk (.*);

// File: tb/sram_lw_core_tb.sv
module sram_lw_core_tb;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int W     = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [3:0]    bws_n = 4'hf;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          drive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [W-1:0]  mem_m [DEPTH];
  logic          p1_rd = 0, p1_wr = 0, p2_wr = 0;
  logic [AW-1:0] p1_a = '0, p2_a = '0;
  logic [3:0]    p1_bws = 4'hf, p2_bws = 4'hf;
  logic [W-1:0]  last_rd = '0;

  always #4 clk = ~clk;

  sram_lw_core #(.DEPTH(DEPTH)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .ce_ni  (ce_n),
    .we_ni  (we_n),
    .bws_ni (bws_n),
    .oe_ni  (oe_n),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .drive_o(drive)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one bus slot: command for this edge, wd is the data-bus word for this edge
  task automatic step(input logic ce, input logic we, input logic [3:0] bws,
                      input logic [AW-1:0] a, input logic [W-1:0] wd, input string tag);
    @(negedge clk);
    ce_n = ce; we_n = we; bws_n = bws; addr = a; wdata = wd;
    @(posedge clk);
    #1;
    if (p2_wr)
      for (int l = 0; l < 4; l++)
        if (!p2_bws[l]) mem_m[p2_a][l*9 +: 9] = wd[l*9 +: 9];
    if (p1_rd) last_rd = mem_m[p1_a];
    chk({tag, " drive"}, {35'd0, drive}, {35'd0, p1_rd});
    chk({tag, " rdata"}, rdata, last_rd);
    p2_wr = p1_wr; p2_a = p1_a; p2_bws = p1_bws;
    p1_rd = !ce && we; p1_wr = !ce && !we; p1_a = a; p1_bws = bws;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 4'hf, '0, '0, tag);
  endtask

  function automatic logic [W-1:0] pat(input int s);
    return {s[8:0] ^ 9'h1a5, s[8:0] ^ 9'h0f3, s[8:0] ^ 9'h16c, s[8:0] ^ 9'h05a};
  endfunction

  task automatic t_fill;  // R2
    for (int i = 0; i < DEPTH; i++)
      step(1'b0, 1'b0, 4'h0, AW'(i), (i >= 2) ? pat(i - 2) : '0, "R2");
    step(1'b1, 1'b1, 4'hf, '0, pat(DEPTH - 2), "R2");
    step(1'b1, 1'b1, 4'hf, '0, pat(DEPTH - 1), "R2");
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 4'hf, AW'(i), '0, "R2");
    idle(2, "R2");
  endtask

  task automatic t_lanes;  // R3
    step(1'b0, 1'b0, 4'b1110, AW'(3), '0, "R3");
    step(1'b0, 1'b0, 4'b0101, AW'(4), '0, "R3");
    step(1'b1, 1'b1, 4'hf, '0, {4{9'h1ff}}, "R3");
    step(1'b1, 1'b1, 4'hf, '0, {4{9'h0aa}}, "R3");
    step(1'b0, 1'b1, 4'hf, AW'(3), '0, "R3");
    step(1'b0, 1'b1, 4'hf, AW'(4), '0, "R3");
    idle(2, "R3");
  endtask

  task automatic t_deselect;  // R1
    step(1'b1, 1'b0, 4'h0, AW'(5), '0, "R1");
    step(1'b1, 1'b0, 4'h0, AW'(6), '0, "R1");
    step(1'b1, 1'b1, 4'hf, '0, {4{9'h133}}, "R1");
    step(1'b0, 1'b1, 4'hf, AW'(5), {4{9'h044}}, "R1");
    step(1'b0, 1'b1, 4'hf, AW'(6), '0, "R1");
    idle(2, "R1");
  endtask

  task automatic t_latency;  // R4
    step(1'b0, 1'b1, 4'hf, AW'(7), '0, "R4");
    idle(1, "R4");
    idle(2, "R4");
    step(1'b0, 1'b1, 4'hf, AW'(8), '0, "R4");
    step(1'b0, 1'b1, 4'hf, AW'(9), '0, "R4");
    idle(3, "R4");
  endtask

  task automatic t_mask;  // R5
    step(1'b0, 1'b1, 4'hf, AW'(1), '0, "R5");
    step(1'b0, 1'b0, 4'h0, AW'(10), '0, "R5");
    step(1'b0, 1'b1, 4'hf, AW'(2), '0, "R5");
    step(1'b1, 1'b1, 4'hf, '0, pat(77), "R5");
    step(1'b0, 1'b1, 4'hf, AW'(10), '0, "R5");
    idle(2, "R5");
  endtask

  task automatic t_oe;  // R6
    step(1'b0, 1'b1, 4'hf, AW'(2), '0, "R6");
    step(1'b1, 1'b1, 4'hf, '0, '0, "R6");
    oe_n = 1'b1; #1;
    chk("R6 oe high drive", {35'd0, drive}, 36'd0);
    oe_n = 1'b0; #1;
    chk("R6 oe low drive", {35'd0, drive}, 36'd1);
    idle(2, "R6");
  endtask

  task automatic t_alternate;  // R7
    step(1'b0, 1'b0, 4'h0, AW'(11), '0, "R7");
    step(1'b0, 1'b1, 4'hf, AW'(12), '0, "R7");
    step(1'b0, 1'b0, 4'h0, AW'(13), pat(300), "R7");
    step(1'b0, 1'b1, 4'hf, AW'(11), '0, "R7");
    step(1'b0, 1'b0, 4'b0011, AW'(12), pat(301), "R7");
    step(1'b0, 1'b1, 4'hf, AW'(13), '0, "R7");
    step(1'b0, 1'b1, 4'hf, AW'(12), pat(302), "R7");
    step(1'b0, 1'b0, 4'h0, AW'(14), '0, "R7");
    step(1'b0, 1'b1, 4'hf, AW'(12), '0, "R7");
    step(1'b0, 1'b1, 4'hf, AW'(14), pat(303), "R7");
    idle(2, "R7");
  endtask

  task automatic t_forward;  // R8
    step(1'b0, 1'b0, 4'b1001, AW'(15), '0, "R8");
    step(1'b0, 1'b1, 4'hf, AW'(15), '0, "R8");
    step(1'b0, 1'b0, 4'h0, AW'(15), {4{9'h155}}, "R8");
    step(1'b0, 1'b1, 4'hf, AW'(15), '0, "R8");
    step(1'b0, 1'b1, 4'hf, AW'(15), {4{9'h0c3}}, "R8");
    idle(2, "R8");
  endtask

  task automatic t_reset_keep;  // R9
    step(1'b0, 1'b1, 4'hf, AW'(0), '0, "R9");
    idle(2, "R9");
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R9 reset drive", {35'd0, drive}, 36'd0);
    chk("R9 reset rdata", rdata, 36'd0);
    last_rd = '0; p1_rd = 0; p1_wr = 0; p2_wr = 0;
    @(negedge clk); rst_n = 1'b1;
    idle(1, "R9");
    step(1'b0, 1'b1, 4'hf, AW'(3), '0, "R9");
    idle(2, "R9");
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset drive", {35'd0, drive}, 36'd0);
    chk("R9 reset rdata", rdata, 36'd0);
    @(negedge clk); rst_n = 1'b1;
    t_fill();
    t_lanes();
    t_deselect();
    t_latency();
    t_mask();
    t_oe();
    t_alternate();
    t_forward();
    t_reset_keep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule